// File: doc/BRIEF.md
# Predicated SIMD Signed Minimum Unit

This block computes a lane-wise signed minimum over two vector operands of a fixed width. The element width is picked at run time from 8, 16, 32 or 64 bits, and all four widths run on one datapath. A byte-granular predicate mask chooses which lanes take the minimum. Every other lane keeps the element of the first operand, so the result can be written back over the first operand's register.

Each input strobe captures the operands, the mask and the width selector. The result and a valid flag appear in a register one clock later. The latency is the same for every operand value and every mask pattern.

Top module: `vmin_pred_unit`

## Requirements
- R1: The width selector `esz` decodes as 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit elements. The vector splits into VLEN/width lanes, and lane k occupies bits k*width upward.
- R2: For an active lane, the output lane holds the smaller of the two operand elements, with both read as two's-complement signed values. This holds at the most negative and most positive values.
- R3: For an inactive lane, the output lane equals the `vec_a` element bit for bit.
- R4: A lane is active exactly when the mask bit of its lowest-numbered byte (mask bit k*width/8) is 1. Mask bits for the higher bytes of a lane have no effect.
- R5: When the two elements of an active lane are equal, the lane outputs that value.
- R6: After a clock edge where `in_stb` is 1, `res_vld` is 1 and `res_vec` holds the new result. After an edge where `in_stb` is 0, `res_vld` is 0 and `res_vec` keeps its value.
- R7: A clock edge with `rst_n` low clears `res_vld` and `res_vec` to 0. The reset is synchronous.
- R8: The latency is always one cycle, with no dependence on operand values, mask or width. Strobes on consecutive cycles each give a result on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_stb | input | 1 | Capture strobe for the operands |
| esz | input | 2 | Element width selector |
| vec_a | input | VLEN | First operand, also the value kept in inactive lanes |
| vec_b | input | VLEN | Second operand |
| pmask | input | VLEN/8 | Predicate mask, one bit per byte |
| res_vec | output | VLEN | Registered result vector |
| res_vld | output | 1 | Result valid, high for one cycle per strobe |

## Verification
The hardest case to reach is a lane whose mask bits disagree, where the low byte's bit is clear and an upper byte's bit is set, at a width wider than a byte. Random masks seldom separate this case from a plain inactive lane. The stimulus table feeds each vector through all four widths, so a mask like 0x5A3C is read as byte, halfword, word and doubleword predicates in turn. Directed 64-bit cases then set only the upper mask bits of a lane, using operands whose minimum differs from `vec_a`.

// File: rtl/vmin_pkg.sv
// Package: shared types for the predicated signed minimum unit.
// Assumes nothing beyond IEEE 1800-2017 packages.
package vmin_pkg;

    // Element width selector; the value is log2(width/8).
    typedef enum logic [1:0] {
        ESZ_B = 2'd0,
        ESZ_H = 2'd1,
        ESZ_W = 2'd2,
        ESZ_D = 2'd3
    } esz_t;

    // Width of one compare chunk, equal to the widest element.
    localparam int CHUNK_W = 64;
    localparam int CHUNK_BYTES = CHUNK_W / 8;

endpackage

// File: rtl/vmin_lane_gate.sv
// Module: vmin_lane_gate
// Widens the per-byte predicate into a per-byte lane-active flag. Each
// byte copies the mask bit of the lowest byte of the lane that holds it.
// Assumes NBYTE is a multiple of 8 so that every lane fits whole.
module vmin_lane_gate
    import vmin_pkg::*;
#(
    parameter int NBYTE = 16
) (
    input  esz_t             esz,
    input  logic [NBYTE-1:0] pmask,
    output logic [NBYTE-1:0] byte_act
);

    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        localparam int BASE_H = i - (i % 2);
        localparam int BASE_W = i - (i % 4);
        localparam int BASE_D = i - (i % 8);
        logic act;
        // Pick the lane base bit for the selected element width.
        always_comb begin
            unique case (esz)
                ESZ_B:   act = pmask[i];
                ESZ_H:   act = pmask[BASE_H];
                ESZ_W:   act = pmask[BASE_W];
                default: act = pmask[BASE_D];
            endcase
        end
        assign byte_act[i] = act;
    end

endmodule

// File: rtl/vmin_chunk_cmp.sv
// Module: vmin_chunk_cmp
// Signed less-than of b against a for one 64-bit chunk, at every element
// width in parallel. The flag for the selected width is spread to each
// byte of its lane. The logic is purely combinational, so its timing does
// not depend on the data.
module vmin_chunk_cmp
    import vmin_pkg::*;
(
    input  esz_t                   esz,
    input  logic [CHUNK_W-1:0]     a,
    input  logic [CHUNK_W-1:0]     b,
    output logic [CHUNK_BYTES-1:0] take_b
);

    localparam int N8  = CHUNK_W / 8;
    localparam int N16 = CHUNK_W / 16;
    localparam int N32 = CHUNK_W / 32;

    logic [N8-1:0]  lt8;
    logic [N16-1:0] lt16;
    logic [N32-1:0] lt32;
    logic           lt64;

    for (genvar g = 0; g < N8; g++) begin : g_lt8
        assign lt8[g] = $signed(b[g*8 +: 8]) < $signed(a[g*8 +: 8]);
    end
    for (genvar g = 0; g < N16; g++) begin : g_lt16
        assign lt16[g] = $signed(b[g*16 +: 16]) < $signed(a[g*16 +: 16]);
    end
    for (genvar g = 0; g < N32; g++) begin : g_lt32
        assign lt32[g] = $signed(b[g*32 +: 32]) < $signed(a[g*32 +: 32]);
    end
    assign lt64 = $signed(b) < $signed(a);

    for (genvar i = 0; i < CHUNK_BYTES; i++) begin : g_sel
        logic pick;
        // Route the compare flag of this byte's lane at the chosen width.
        always_comb begin
            unique case (esz)
                ESZ_B:   pick = lt8[i];
                ESZ_H:   pick = lt16[i/2];
                ESZ_W:   pick = lt32[i/4];
                default: pick = lt64;
            endcase
        end
        assign take_b[i] = pick;
    end

endmodule

// File: rtl/vmin_byte_merge.sv
// Module: vmin_byte_merge
// Byte-wise multiplexer: a byte takes b when its lane is active and b is
// the smaller value, and keeps a otherwise. Both select inputs must
// already be consistent across each lane.
module vmin_byte_merge #(
    parameter int NBYTE = 16
) (
    input  logic [NBYTE*8-1:0] a,
    input  logic [NBYTE*8-1:0] b,
    input  logic [NBYTE-1:0]   act,
    input  logic [NBYTE-1:0]   take_b,
    output logic [NBYTE*8-1:0] y
);

    for (genvar i = 0; i < NBYTE; i++) begin : g_mux
        assign y[i*8 +: 8] = (act[i] && take_b[i]) ? b[i*8 +: 8] : a[i*8 +: 8];
    end

endmodule

// File: rtl/vmin_pred_unit.sv
// Module: vmin_pred_unit (top)
// Predicated lane-wise signed minimum with a run-time element width.
// Inputs are captured on in_stb, and the result is registered one cycle
// later, the same for every operand and mask. Inactive lanes return
// vec_a. Assumes VLEN is a positive multiple of 64. Reset is synchronous
// and active low.
module vmin_pred_unit
    import vmin_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_stb,
    input  logic [1:0]        esz,
    input  logic [VLEN-1:0]   vec_a,
    input  logic [VLEN-1:0]   vec_b,
    input  logic [VLEN/8-1:0] pmask,
    output logic [VLEN-1:0]   res_vec,
    output logic              res_vld
);

    localparam int NBYTE  = VLEN / 8;
    localparam int NCHUNK = VLEN / CHUNK_W;

    esz_t             esz_e;
    logic [NBYTE-1:0] byte_act;
    logic [NBYTE-1:0] take_b;
    logic [VLEN-1:0]  merged;

    assign esz_e = esz_t'(esz);

    vmin_lane_gate #(.NBYTE(NBYTE)) u_gate (
        .esz      (esz_e),
        .pmask    (pmask),
        .byte_act (byte_act)
    );

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        vmin_chunk_cmp u_cmp (
            .esz    (esz_e),
            .a      (vec_a[c*CHUNK_W +: CHUNK_W]),
            .b      (vec_b[c*CHUNK_W +: CHUNK_W]),
            .take_b (take_b[c*CHUNK_BYTES +: CHUNK_BYTES])
        );
    end

    vmin_byte_merge #(.NBYTE(NBYTE)) u_merge (
        .a      (vec_a),
        .b      (vec_b),
        .act    (byte_act),
        .take_b (take_b),
        .y      (merged)
    );

    // Result register: capture on strobe, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld <= 1'b0;
            res_vec <= '0;
        end else begin
            res_vld <= in_stb;
            if (in_stb) begin
                res_vec <= merged;
            end
        end
    end

endmodule

// File: rtl/vmin_pred_checker.sv
// Module: vmin_pred_checker
// Properties over the ports of vmin_pred_unit, attached with bind.
module vmin_pred_checker #(
    parameter int VLEN = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_stb,
    input logic [1:0]        esz,
    input logic [VLEN-1:0]   vec_a,
    input logic [VLEN-1:0]   vec_b,
    input logic [VLEN/8-1:0] pmask,
    input logic [VLEN-1:0]   res_vec,
    input logic              res_vld
);

    assert_vld_after_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_stb |=> res_vld);

    assert_idle_no_vld_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_stb |=> (!res_vld && $stable(res_vec)));

    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (!res_vld && res_vec == '0));

    assert_mask_off_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && pmask == '0) |=> res_vec == $past(vec_a));

    assert_dword_low_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && esz == 2'd3 && !pmask[0]) |=> res_vec[63:0] == $past(vec_a[63:0]));

    assert_dword_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && esz == 2'd3 && pmask[0]) |=>
        ($signed(res_vec[63:0]) <= $signed($past(vec_a[63:0])) &&
         $signed(res_vec[63:0]) <= $signed($past(vec_b[63:0])) &&
         (res_vec[63:0] == $past(vec_a[63:0]) || res_vec[63:0] == $past(vec_b[63:0]))));

endmodule

bind vmin_pred_unit vmin_pred_checker #(.VLEN(VLEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_stb  (in_stb),
    .esz     (esz),
    .vec_a   (vec_a),
    .vec_b   (vec_b),
    .pmask   (pmask),
    .res_vec (res_vec),
    .res_vld (res_vld)
);

// File: tb/sim_vmin_pred_unit.sv
module sim_vmin_pred_unit;

    localparam int VLEN = 128;
    localparam int NT = 8;

    localparam logic [127:0] TA [NT] = '{
        128'h80808080_80808080_80808080_80808080,
        128'h7F7F7F7F_7F7F7F7F_7F7F7F7F_7F7F7F7F,
        128'h00112233_44556677_8899AABB_CCDDEEFF,
        128'h80000000_00000000_7FFFFFFF_FFFFFFFF,
        128'h01234567_89ABCDEF_FEDCBA98_76543210,
        128'h00000000_00000000_00000000_00000000,
        128'h80000000_7FFFFFFF_00000001_FFFFFFFF,
        128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF
    };
    localparam logic [127:0] TB [NT] = '{
        128'h7F7F7F7F_7F7F7F7F_7F7F7F7F_7F7F7F7F,
        128'h80808080_80808080_80808080_80808080,
        128'hFFEEDDCC_BBAA9988_77665544_33221100,
        128'h7FFFFFFF_FFFFFFFF_80000000_00000000,
        128'h13579BDF_02468ACE_ECA86420_FDB97531,
        128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
        128'h7FFFFFFF_80000000_FFFFFFFF_00000001,
        128'h00000000_80000000_00007FFF_80808080
    };
    localparam logic [15:0] TM [NT] = '{
        16'hFFFF, 16'hFFFF, 16'hAAAA, 16'h0101,
        16'h5A3C, 16'h00FF, 16'hFFFF, 16'h1111
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_stb = 1'b0;
    logic [1:0]        esz = 2'd0;
    logic [VLEN-1:0]   vec_a = '0;
    logic [VLEN-1:0]   vec_b = '0;
    logic [VLEN/8-1:0] pmask = '0;
    logic [VLEN-1:0]   res_vec;
    logic              res_vld;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vmin_pred_unit #(.VLEN(VLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .esz(esz),
        .vec_a(vec_a), .vec_b(vec_b), .pmask(pmask),
        .res_vec(res_vec), .res_vld(res_vld)
    );

    // Reference model: per-lane signed min using offset-binary compare.
    function automatic logic [127:0] ref_min(input logic [127:0] a, input logic [127:0] b,
                                             input logic [15:0] m, input logic [1:0] sz);
        int w;
        logic [127:0] r;
        logic [63:0] ea, eb, msk, sb;
        w = 8 << sz;
        r = a;
        msk = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        sb = 64'd1 << (w - 1);
        for (int l = 0; l < 128 / w; l++) begin
            ea = 64'(a >> (l * w)) & msk;
            eb = 64'(b >> (l * w)) & msk;
            if (m[(l * w) / 8] && ((eb ^ sb) < (ea ^ sb)))
                r = (r & ~(128'(msk) << (l * w))) | (128'(eb) << (l * w));
        end
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    // Strobe one operation and check the result one edge later.
    task automatic apply(input string tag, input logic [127:0] a, input logic [127:0] b,
                         input logic [15:0] m, input logic [1:0] sz);
        @(negedge clk);
        in_stb = 1'b1; vec_a = a; vec_b = b; pmask = m; esz = sz;
        @(posedge clk);
        #1;
        check_bit({tag, " R8 vld"}, res_vld, 1'b1);
        check_vec(tag, res_vec, ref_min(a, b, m, sz));
    endtask

    initial begin
        logic [127:0] held;
        // R7: reset state
        repeat (3) @(posedge clk);
        #1;
        check_bit("R7 reset vld", res_vld, 1'b0);
        check_vec("R7 reset data", res_vec, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3: table walked at every element width
        for (int i = 0; i < NT; i++) begin
            for (int s = 0; s < 4; s++) begin
                apply($sformatf("R1 R2 R3 vec%0d esz%0d", i, s), TA[i], TB[i], TM[i], 2'(s));
            end
        end

        // R5: equal operands
        apply("R5 equal byte", 128'h80FF7F00_12345678_9ABCDEF0_80007FFF,
              128'h80FF7F00_12345678_9ABCDEF0_80007FFF, 16'hFFFF, 2'd0);
        check_vec("R5 equal value", res_vec, 128'h80FF7F00_12345678_9ABCDEF0_80007FFF);

        // R4: upper mask bits of 64-bit lanes set, low bits clear -> inactive
        apply("R4 upper bits only", {64'd5, 64'd1}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000},
              16'hFEFE, 2'd3);
        check_vec("R4 kept a", res_vec, {64'd5, 64'd1});
        apply("R4 low bit only", {64'd5, 64'd1}, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000},
              16'h0101, 2'd3);
        check_vec("R4 took b", res_vec, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000});
        apply("R4 halfword upper bits", 128'h0001_0001_0001_0001_0001_0001_0001_0001,
              128'h8000_8000_8000_8000_8000_8000_8000_8000, 16'hAAAA, 2'd1);
        check_vec("R4 halfword kept a", res_vec, 128'h0001_0001_0001_0001_0001_0001_0001_0001);

        // R6: idle cycle holds data and drops valid
        held = res_vec;
        @(negedge clk);
        in_stb = 1'b0; vec_a = ~vec_a; vec_b = '0; pmask = '1;
        @(posedge clk);
        #1;
        check_bit("R6 idle vld", res_vld, 1'b0);
        check_vec("R6 idle hold", res_vec, held);

        // R8: back-to-back strobes
        apply("R8 b2b first", TA[4], TB[4], 16'hFFFF, 2'd2);
        apply("R8 b2b second", TB[4], TA[4], 16'hFFFF, 2'd2);

        // R7: reset after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_bit("R7 mid reset vld", res_vld, 1'b0);
        check_vec("R7 mid reset data", res_vec, '0);
        @(negedge clk);
        rst_n = 1'b1; in_stb = 1'b0;
        @(posedge clk);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule